// File: doc/BRIEF.md
# Two-Channel Bus Breakpoint Comparator

This block watches every access on a processor's internal bus and raises a break request when an access meets the conditions programmed into one of its two channels. Each channel holds a target address and a per-bit address mask. It also holds a condition word that selects the access kinds it responds to (instruction fetch, data access, or both), the directions (read, write, or both) and the operand size (any, byte, word or longword). The second channel can also compare the transferred operand against a target value through a per-bit data mask. The two channels run independently, and a hit on either one raises the shared break request.

A data-access hit raises its break in the cycle after the access. A fetch hit is timed against instruction progress instead. In the early mode, the break is issued when the fetched instruction enters execute, before it commits. In the late mode, the break is issued once that instruction retires. Each channel has a per-channel state machine with four states:

- `S_IDLE`: armed and watching.
- `S_PRE_WAIT`: an early-mode fetch hit is waiting for execute.
- `S_POST_EXEC`: a late-mode fetch hit is waiting for execute.
- `S_POST_RET`: the matched instruction is executing and the channel is waiting for retire.

The transitions are:

- `S_IDLE` to `S_PRE_WAIT` on an early-mode fetch hit.
- `S_IDLE` to `S_POST_EXEC` on a late-mode fetch hit.
- `S_PRE_WAIT` to `S_IDLE` on `ex_go`, which issues the break.
- `S_POST_EXEC` to `S_POST_RET` on `ex_go`.
- `S_POST_RET` to `S_IDLE` on `retire`, which issues the break.
- Any state to `S_IDLE` on a write to that channel's condition word, which cancels the pending break.

Top module: `bus_break_unit`

## Requirements
- R1: After reset, `brk_req`, `brk_a`, `brk_b`, `hit_a` and `hit_b` are low and both condition words are zero (kind field 00 = off), so no access raises a break.
- R2: An address byte matches the channel target when every bit whose mask bit is 0 equals the target bit; mask bits set to 1 exclude that bit (target 0x8404 mask 0xFFF covers 0x8000..0x8FFF; target 0x8010 mask 0x6 covers 0x8010..0x8016 for aligned word fetches).
- R3: An access covers 1, 2 or 4 byte lanes (`bus_size` 0 = byte, 1 = word, 2 = longword), starting at `bus_addr[1:0]` rounded down to the size; the address condition holds when any covered byte matches (a longword read at 0x123454 meets target 0x123456, a word read at 0x123454 does not).
- R4: Condition word bits [1:0] select the kind (bit 0 enables fetches, bit 1 enables data accesses) and bits [3:2] select the direction (bit 2 reads, bit 3 writes); an access of a disabled kind or direction never hits.
- R5: Condition bits [5:4] give the size filter: 00 any size, 01 byte, 10 word, 11 longword; any other size never hits.
- R6: When condition bit 7 is set on channel B, the operand, taken from the covered lanes and shifted down to bit 0 (lane n is `bus_data[8n+7:8n]`), must equal the data target on every covered bit whose data mask bit is 0.
- R7: A data-access hit raises that channel's break output for exactly one cycle, in the cycle after the access.
- R8: With condition bit 6 clear, a fetch hit raises the break in the cycle after the next `ex_go` pulse.
- R9: With condition bit 6 set, a fetch hit raises the break in the cycle after the first `retire` that follows the next `ex_go`.
- R10: `brk_req` is high exactly when `brk_a` or `brk_b` is high, and each channel breaks regardless of the other.
- R11: `hit_a` / `hit_b` go high with the channel's first break and stay high until that channel's condition word is written; that write also cancels a pending fetch break and suppresses a break in the same cycle.
- R12: The write port selector maps 0/1/2 to channel A target, mask and condition, and 3/4/5/6/7 to channel B target, mask, condition, data target and data mask; a write reaches only the register it selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register selector |
| cfg_wdata | input | 32 | Register write data |
| bus_valid | input | 1 | An access is on the bus this cycle |
| bus_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0 byte, 1 word, 2 longword |
| bus_addr | input | 32 | Access byte address |
| bus_data | input | 32 | Access data in its byte lanes |
| ex_go | input | 1 | The last fetched instruction enters execute |
| retire | input | 1 | The executing instruction completes |
| brk_req | output | 1 | Combined break request |
| brk_a | output | 1 | Channel A break pulse |
| brk_b | output | 1 | Channel B break pulse |
| hit_a | output | 1 | Channel A sticky hit flag |
| hit_b | output | 1 | Channel B sticky hit flag |

## Verification
The checks assume strictly sequential instruction flow: a fetch happens only when no earlier instruction is between fetch and retire, `ex_go` follows that fetch before the next one, and `retire` follows `ex_go` and never shares a cycle with it. The random stimulus tracks an instruction phase so it issues a fetch, then `ex_go`, then `retire`, in that order. Data accesses and condition writes are placed freely, including in the same cycle as `ex_go`. Accesses are always byte, word or longword. Their addresses are kept near the programmed targets so that hits and misses both occur often.

// File: rtl/bbu_pkg.sv
package bbu_pkg;

    localparam int COND_W = 8;

    typedef enum logic [1:0] {
        K_OFF   = 2'b00,
        K_FETCH = 2'b01,
        K_DATA  = 2'b10,
        K_BOTH  = 2'b11
    } kind_e;

    typedef struct packed {
        logic       data_en;
        logic       after;
        logic [1:0] size;
        logic [1:0] dir;
        kind_e      kind;
    } cond_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_PRE_WAIT,
        S_POST_EXEC,
        S_POST_RET
    } ch_state_e;

    localparam logic [2:0] SEL_A_ADDR  = 3'd0;
    localparam logic [2:0] SEL_A_COND  = 3'd2;
    localparam logic [2:0] SEL_B_COND  = 3'd5;
    localparam logic [2:0] SEL_B_DATA  = 3'd6;
    localparam logic [2:0] SEL_B_DMASK = 3'd7;
    localparam int         SEL_STRIDE  = 3;

endpackage

// File: rtl/bbu_lane_cmp.sv
module bbu_lane_cmp #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic [1:0]    size,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data,
    input  logic [AW-1:0] ref_addr,
    input  logic [AW-1:0] ref_amask,
    input  logic [DW-1:0] ref_data,
    input  logic [DW-1:0] ref_dmask,
    output logic          addr_hit,
    output logic          data_hit
);
    localparam int LANES = DW / 8;
    localparam int LW    = $clog2(LANES);

    logic [1:0]       sz_eff;
    logic [LW:0]      nbytes;
    logic [LW:0]      base;
    logic [LANES-1:0] lane_hit;
    logic [DW-1:0]    size_mask;
    logic [DW-1:0]    aligned;

    always_comb begin
        sz_eff = (int'(size) > LW) ? 2'(LW) : size;
        nbytes = (LW+1)'(1) << sz_eff;
        base   = {1'b0, addr[LW-1:0]} & ~(nbytes - (LW+1)'(1));
    end

    for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
        localparam logic [LW:0] IDX = (LW+1)'(gi);
        logic [AW-1:0] lane_addr;
        logic          lane_on;
        assign lane_addr        = {addr[AW-1:LW], IDX[LW-1:0]};
        assign lane_on          = (IDX >= base) && (IDX < base + nbytes);
        assign lane_hit[gi]     = lane_on && (((lane_addr ^ ref_addr) & ~ref_amask) == '0);
        assign size_mask[8*gi +: 8] = {8{IDX < nbytes}};
    end

    assign aligned  = data >> {base, 3'b000};
    assign addr_hit = |lane_hit;
    assign data_hit = (((aligned ^ ref_data) & ~ref_dmask & size_mask) == '0);

endmodule

// File: rtl/bbu_channel.sv
module bbu_channel
    import bbu_pkg::*;
#(
    parameter int AW       = 32,
    parameter int DW       = 32,
    parameter bit HAS_DATA = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_addr_en,
    input  logic          wr_mask_en,
    input  logic          wr_cond_en,
    input  logic          wr_data_en,
    input  logic          wr_dmask_en,
    input  logic [DW-1:0] wdata,
    input  logic          bus_valid,
    input  logic          bus_fetch,
    input  logic          bus_write,
    input  logic [1:0]    bus_size,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_data,
    input  logic          ex_go,
    input  logic          retire,
    output logic          brk,
    output logic          hit
);
    logic [AW-1:0] tgt_addr_q, tgt_mask_q;
    logic [DW-1:0] tgt_data_q, tgt_dmask_q;
    cond_t         cond_q;
    ch_state_e     state_q, state_nx;
    logic          brk_set;
    logic          addr_ok, data_ok;
    logic          kind_ok, dir_ok, size_ok, data_need, hit_now;

    // condition registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_addr_q  <= '0;
            tgt_mask_q  <= '0;
            tgt_data_q  <= '0;
            tgt_dmask_q <= '0;
            cond_q      <= '0;
        end else begin
            if (wr_addr_en)  tgt_addr_q  <= wdata[AW-1:0];
            if (wr_mask_en)  tgt_mask_q  <= wdata[AW-1:0];
            if (wr_cond_en)  cond_q      <= cond_t'(wdata[COND_W-1:0]);
            if (wr_data_en)  tgt_data_q  <= wdata;
            if (wr_dmask_en) tgt_dmask_q <= wdata;
        end
    end

    bbu_lane_cmp #(.AW(AW), .DW(DW)) u_cmp (
        .size      (bus_size),
        .addr      (bus_addr),
        .data      (bus_data),
        .ref_addr  (tgt_addr_q),
        .ref_amask (tgt_mask_q),
        .ref_data  (tgt_data_q),
        .ref_dmask (tgt_dmask_q),
        .addr_hit  (addr_ok),
        .data_hit  (data_ok)
    );

    // cycle-type qualification
    always_comb begin
        kind_ok   = bus_fetch ? cond_q.kind[0] : cond_q.kind[1];
        dir_ok    = bus_write ? cond_q.dir[1] : cond_q.dir[0];
        size_ok   = (cond_q.size == 2'd0) || (cond_q.size == bus_size + 2'd1);
        data_need = HAS_DATA && cond_q.data_en;
        hit_now   = bus_valid && kind_ok && dir_ok && size_ok && addr_ok
                    && (!data_need || data_ok);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_nx;
    end

    // next state and break issue
    always_comb begin
        state_nx = state_q;
        brk_set  = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (hit_now && bus_fetch)
                    state_nx = cond_q.after ? S_POST_EXEC : S_PRE_WAIT;
            end
            S_PRE_WAIT: begin
                if (ex_go) begin
                    state_nx = S_IDLE;
                    brk_set  = 1'b1;
                end
            end
            S_POST_EXEC: begin
                if (ex_go) state_nx = S_POST_RET;
            end
            S_POST_RET: begin
                if (retire) begin
                    state_nx = S_IDLE;
                    brk_set  = 1'b1;
                end
            end
            default: state_nx = S_IDLE;
        endcase
        if (hit_now && !bus_fetch) brk_set = 1'b1;
        if (wr_cond_en) begin
            state_nx = S_IDLE;
            brk_set  = 1'b0;
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            brk <= 1'b0;
            hit <= 1'b0;
        end else begin
            brk <= brk_set;
            hit <= wr_cond_en ? 1'b0 : (hit | brk_set);
        end
    end

endmodule

// File: rtl/bus_break_unit.sv
module bus_break_unit
    import bbu_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_sel,
    input  logic [DW-1:0] cfg_wdata,
    input  logic          bus_valid,
    input  logic          bus_fetch,
    input  logic          bus_write,
    input  logic [1:0]    bus_size,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_data,
    input  logic          ex_go,
    input  logic          retire,
    output logic          brk_req,
    output logic          brk_a,
    output logic          brk_b,
    output logic          hit_a,
    output logic          hit_b
);
    localparam int NCH = 2;

    logic [NCH-1:0] brk_v, hit_v;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam logic [2:0] BASE = 3'(c * SEL_STRIDE);
        localparam bit         DATA = (c == NCH - 1);
        logic we_addr, we_mask, we_cond, we_data, we_dmask;
        assign we_addr  = cfg_we && (cfg_sel == BASE + SEL_A_ADDR);
        assign we_mask  = cfg_we && (cfg_sel == BASE + 3'd1);
        assign we_cond  = cfg_we && (cfg_sel == BASE + SEL_A_COND);
        assign we_data  = DATA && cfg_we && (cfg_sel == SEL_B_DATA);
        assign we_dmask = DATA && cfg_we && (cfg_sel == SEL_B_DMASK);

        bbu_channel #(.AW(AW), .DW(DW), .HAS_DATA(DATA)) u_ch (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_addr_en  (we_addr),
            .wr_mask_en  (we_mask),
            .wr_cond_en  (we_cond),
            .wr_data_en  (we_data),
            .wr_dmask_en (we_dmask),
            .wdata       (cfg_wdata),
            .bus_valid   (bus_valid),
            .bus_fetch   (bus_fetch),
            .bus_write   (bus_write),
            .bus_size    (bus_size),
            .bus_addr    (bus_addr),
            .bus_data    (bus_data),
            .ex_go       (ex_go),
            .retire      (retire),
            .brk         (brk_v[c]),
            .hit         (hit_v[c])
        );
    end

    assign brk_a   = brk_v[0];
    assign brk_b   = brk_v[1];
    assign hit_a   = hit_v[0];
    assign hit_b   = hit_v[1];
    assign brk_req = |brk_v;

endmodule

// File: rtl/bbu_checker.sv
module bbu_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_we,
    input logic [2:0] cfg_sel,
    input logic       bus_valid,
    input logic       ex_go,
    input logic       retire,
    input logic       brk_req,
    input logic       brk_a,
    input logic       brk_b,
    input logic       hit_a,
    input logic       hit_b
);
    // R11: flag rises only together with a break
    a_r11_rise_with_break: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hit_a) |-> brk_a) and ($rose(hit_b) |-> brk_b));

    // R11: flag holds until the condition word is rewritten
    a_r11_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_a && !(cfg_we && cfg_sel == 3'd2)) |=> hit_a);

    // R11: condition write clears flag and break
    a_r11_cond_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel == 3'd5) |=> (!hit_b && !brk_b));

    // R8 and R9: a break without a prior access comes from instruction progress
    a_r8_fetch_break_source: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_b && !$past(bus_valid)) |-> $past(ex_go || retire));

    // R10: no request without a source in the previous cycle
    a_r10_quiet_no_request: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_valid && !ex_go && !retire) |=> !brk_req);
endmodule

bind bus_break_unit bbu_checker u_chk (.*);

// File: tb/sim_bus_break_unit.sv
module sim_bus_break_unit;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        bus_valid = 1'b0, bus_fetch = 1'b0, bus_write = 1'b0;
    logic [1:0]  bus_size = '0;
    logic [31:0] bus_addr = '0, bus_data = '0;
    logic        ex_go = 1'b0, retire = 1'b0;
    logic        brk_req, brk_a, brk_b, hit_a, hit_b;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    bus_break_unit u0 (.*);

    always #(CLK_P/2) clk = ~clk;

    // behavioural reference state
    logic [31:0] m_addr[2], m_mask[2];
    logic [7:0]  m_cond[2];
    logic [31:0] m_data, m_dmask;
    int          m_pend[2];
    bit          m_brk[2], m_hit[2];

    function automatic bit m_match(int ch, bit f, bit w, logic [1:0] sz,
                                   logic [31:0] a, logic [31:0] d);
        logic [7:0] c = m_cond[ch];
        int n = 1 << sz;
        int off = (a[1:0] / n) * n;
        bit any = 0;
        if (f ? !c[0] : !c[1]) return 0;
        if (w ? !c[3] : !c[2]) return 0;
        if (c[5:4] != 0 && int'(c[5:4]) != int'(sz) + 1) return 0;
        for (int k = 0; k < n; k++) begin
            logic [31:0] ba = {a[31:2], 2'b00} + 32'(off + k);
            if (((ba ^ m_addr[ch]) & ~m_mask[ch]) == 0) any = 1;
        end
        if (!any) return 0;
        if (ch == 1 && c[7]) begin
            logic [31:0] v = d >> (8 * off);
            logic [31:0] sm = (n == 4) ? 32'hFFFF_FFFF : ((32'h1 << (8 * n)) - 1);
            if (((v ^ m_data) & ~m_dmask & sm) != 0) return 0;
        end
        return 1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int ch = 0; ch < 2; ch++) begin
                m_addr[ch] = 0; m_mask[ch] = 0; m_cond[ch] = 0;
                m_pend[ch] = 0; m_brk[ch] = 0; m_hit[ch] = 0;
            end
            m_data = 0; m_dmask = 0;
        end else begin
            for (int ch = 0; ch < 2; ch++) begin
                bit h = bus_valid && m_match(ch, bus_fetch, bus_write, bus_size, bus_addr, bus_data);
                bit nb = 0;
                bit cw = cfg_we && (cfg_sel == 3'(ch * 3 + 2));
                case (m_pend[ch])
                    0: if (h && bus_fetch) m_pend[ch] = m_cond[ch][6] ? 2 : 1;
                    1: if (ex_go) begin m_pend[ch] = 0; nb = 1; end
                    2: if (ex_go) m_pend[ch] = 3;
                    default: if (retire) begin m_pend[ch] = 0; nb = 1; end
                endcase
                if (h && !bus_fetch) nb = 1;
                if (cw) begin m_pend[ch] = 0; nb = 0; m_hit[ch] = 0; end
                else m_hit[ch] = m_hit[ch] | nb;
                m_brk[ch] = nb;
            end
            if (cfg_we) begin
                case (cfg_sel)
                    3'd0: m_addr[0] = cfg_wdata;
                    3'd1: m_mask[0] = cfg_wdata;
                    3'd2: m_cond[0] = cfg_wdata[7:0];
                    3'd3: m_addr[1] = cfg_wdata;
                    3'd4: m_mask[1] = cfg_wdata;
                    3'd5: m_cond[1] = cfg_wdata[7:0];
                    3'd6: m_data = cfg_wdata;
                    default: m_dmask = cfg_wdata;
                endcase
            end
        end
    end

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // every-cycle comparison with the reference (R10 and the channel outputs)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [4:0] act = {brk_req, brk_a, brk_b, hit_a, hit_b};
            logic [4:0] exp = {m_brk[0] | m_brk[1], m_brk[0], m_brk[1], m_hit[0], m_hit[1]};
            chk(act == exp, "R10 model compare {req,a,b,ha,hb}", 32'(act), 32'(exp));
        end
    end

    task automatic wr(logic [2:0] s, logic [31:0] v);
        cfg_we = 1; cfg_sel = s; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic acc(bit f, bit w, logic [1:0] sz, logic [31:0] a, logic [31:0] d);
        bus_valid = 1; bus_fetch = f; bus_write = w; bus_size = sz; bus_addr = a; bus_data = d;
        @(negedge clk);
        bus_valid = 0;
    endtask

    task automatic go_ex();  ex_go = 1;  @(negedge clk); ex_go = 0;  endtask
    task automatic go_ret(); retire = 1; @(negedge clk); retire = 0; endtask

    task automatic summary();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_P * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk({brk_req, hit_a, hit_b} == 0, "R1 reset outputs", {brk_req, hit_a, hit_b}, 0);
        acc(0, 0, 2, 32'h0, 32'h0);
        chk(brk_req == 0, "R1 conditions off after reset", brk_req, 0);

        // late fetch break, range 0x8000..0x8FFF
        wr(0, 32'h8404); wr(1, 32'hFFF); wr(2, 32'h45);
        acc(1, 0, 2, 32'h8000, 0);
        chk(brk_a == 0, "R9 no break at fetch", brk_a, 0);
        go_ex();
        chk(brk_a == 0, "R9 no break at execute", brk_a, 0);
        go_ret();
        chk(brk_a == 1, "R9 break after retire", brk_a, 1);
        @(negedge clk);
        chk(brk_a == 0 && hit_a == 1, "R11 pulse ends, flag holds", {brk_a, hit_a}, 2'b01);
        acc(1, 0, 1, 32'h9000, 0); go_ex(); go_ret();
        chk(brk_a == 0, "R2 outside masked range", brk_a, 0);
        acc(1, 0, 1, 32'h8FFE, 0); go_ex(); go_ret();
        chk(brk_a == 1, "R2 top of masked range", brk_a, 1);

        // early fetch break, 0x8010 mask 6
        wr(0, 32'h8010); wr(1, 32'h6); wr(2, 32'h05);
        chk(hit_a == 0, "R11 condition write clears flag", hit_a, 0);
        acc(1, 0, 1, 32'h8016, 0);
        chk(brk_a == 0, "R8 waits for execute", brk_a, 0);
        go_ex();
        chk(brk_a == 1, "R8 break at execute", brk_a, 1);
        acc(1, 0, 1, 32'h8018, 0); go_ex();
        chk(brk_a == 0, "R2 0x8018 outside mask 6", brk_a, 0);

        // data read, size free, lane coverage
        wr(0, 32'h123456); wr(1, 0); wr(2, 32'h06);
        acc(0, 0, 2, 32'h123454, 0);
        chk(brk_a == 1, "R3 longword covers target", brk_a, 1);
        acc(0, 0, 1, 32'h123456, 0);
        chk(brk_a == 1, "R7 word read hit", brk_a, 1);
        acc(0, 0, 0, 32'h123456, 0);
        chk(brk_a == 1, "R3 byte read hit", brk_a, 1);
        acc(0, 0, 0, 32'h123457, 0);
        chk(brk_a == 0, "R3 neighbour byte", brk_a, 0);
        acc(0, 0, 1, 32'h123454, 0);
        chk(brk_a == 0, "R3 word not covering target", brk_a, 0);
        acc(0, 1, 1, 32'h123456, 0);
        chk(brk_a == 0, "R4 write ignored by read condition", brk_a, 0);
        acc(1, 0, 1, 32'h123456, 0); go_ex();
        chk(brk_a == 0, "R4 fetch ignored by data condition", brk_a, 0);

        wr(2, 32'h26);
        acc(0, 0, 2, 32'h123454, 0);
        chk(brk_a == 0, "R5 longword filtered by word size", brk_a, 0);
        acc(0, 0, 1, 32'h123456, 0);
        chk(brk_a == 1, "R5 word passes size filter", brk_a, 1);

        // channel B data compare
        wr(3, 32'hABCDE); wr(4, 32'hFF); wr(6, 32'hA512); wr(7, 0); wr(5, 32'hAA);
        acc(0, 1, 1, 32'hABC10, 32'h0000A512);
        chk(brk_b == 1 && brk_a == 0 && brk_req == 1, "R10 channel B alone", {brk_b, brk_a, brk_req}, 3'b101);
        acc(0, 1, 1, 32'hABCFE, 32'hA5120000);
        chk(brk_b == 1, "R6 upper lanes value", brk_b, 1);
        acc(0, 1, 1, 32'hABCFE, 32'h0000A512);
        chk(brk_b == 0, "R6 value in wrong lanes", brk_b, 0);
        acc(0, 1, 1, 32'hABD00, 32'h0000A512);
        chk(brk_b == 0, "R2 outside B range", brk_b, 0);
        acc(0, 1, 1, 32'hABC10, 32'h0000A513);
        chk(brk_b == 0, "R6 data mismatch", brk_b, 0);
        wr(7, 1);
        acc(0, 1, 1, 32'hABC10, 32'h0000A513);
        chk(brk_b == 1, "R6 masked data bit", brk_b, 1);

        // both channels
        wr(3, 32'h123456); wr(4, 0); wr(5, 32'h06);
        acc(0, 0, 1, 32'h123456, 0);
        chk({brk_a, brk_b, brk_req} == 3'b111, "R10 both channels", {brk_a, brk_b, brk_req}, 3'b111);

        // cancel by condition write, selector isolation
        wr(0, 32'h8010); wr(1, 32'h6); wr(2, 32'h05);
        acc(1, 0, 1, 32'h8010, 0);
        wr(2, 32'h05);
        go_ex();
        chk(brk_a == 0 && hit_a == 0, "R11 pending break cancelled", {brk_a, hit_a}, 0);
        acc(1, 0, 1, 32'h8010, 0);
        wr(3, 32'hFFFF0000);
        go_ex();
        chk(brk_a == 1, "R12 B write leaves A intact", brk_a, 1);

        // random phase against the reference model
        wr(0, 32'h1000); wr(1, 32'h0C); wr(3, 32'h2004); wr(4, 32'h3);
        wr(6, 32'h5A); wr(7, 32'hF0);
        begin
            int ph = 0;
            for (int i = 0; i < 6000; i++) begin
                int ph0 = ph;
                ex_go = 0; retire = 0; bus_valid = 0; cfg_we = 0;
                if (ph0 == 1 && $urandom % 3 == 0) begin ex_go = 1; ph = 2; end
                else if (ph0 == 2 && $urandom % 3 == 0) begin retire = 1; ph = 0; end
                if ($urandom % 2) begin
                    bus_valid = 1;
                    bus_fetch = (ph0 == 0) && !retire && ($urandom % 2);
                    if (bus_fetch) ph = 1;
                    bus_write = bus_fetch ? 1'b0 : 1'($urandom % 2);
                    bus_size  = 2'($urandom % 3);
                    bus_addr  = (($urandom % 2) ? 32'h1000 : 32'h2000) ^ 32'($urandom % 32);
                    bus_data  = ($urandom % 2) ? 32'h5A5A5A5A : $urandom;
                end
                if (i % 150 == 0) begin
                    cfg_we = 1;
                    cfg_sel = ($urandom % 2) ? 3'd2 : 3'd5;
                    cfg_wdata = 32'($urandom % 256) | 32'h1;
                end
                @(negedge clk);
            end
            ex_go = 0; retire = 0; bus_valid = 0; cfg_we = 0;
        end
        repeat (3) @(negedge clk);
        summary();
    end
endmodule